// File: doc/BRIEF.md
# Strobe-Paced 8N1 Byte Serializer

This block turns one byte into an 8N1 serial frame: a low start slot, eight data slots with the most significant bit first, and a high stop slot. It has no baud timer. Each pulse on a bit-advance strobe moves the frame forward by exactly one slot, so the caller sets the bit rate, or can pace bits from any other event.

The frame position is a counter that runs from 0 to 9. Value 9 is both the idle state and the stop slot. Value 0 carries the start bit, and values 1 to 8 carry data bits 7 down to 0.

The counter is also a block output. A paired receiver that advances on the same strobe can use it to stay in lockstep with the transmitter.

Bytes come in over a valid/ready handshake. A byte is captured only in idle, and only while no byte is already waiting. The frame starts on the first strobe after the capture. A byte can therefore be accepted in the same cycle the counter returns to 9, but the stop slot still lasts until the next strobe.

Top module: `ser8n1_tx`

## Requirements
- R1: While reset is asserted and on leaving reset, the counter output is 9, the line is high and ready is high.
- R2: Ready is high exactly when the counter is 9 and no byte is waiting. A byte is captured at a rising clock edge where valid and ready are both high.
- R3: With the counter at 9 and no byte waiting, the advance strobe changes neither the counter nor the line.
- R4: The first strobe after a byte is captured moves the counter from 9 to 0 and drives the line low (the start bit). A strobe in the same cycle as the capture does not count.
- R5: With the counter between 0 and 8, each strobe adds one to it, so 8 steps to 9.
- R6: While the counter holds a value k from 1 to 8, the line carries bit (8 − k) of the captured byte. The data therefore leaves most significant bit first.
- R7: The line is high whenever the counter is 9.
- R8: Without a strobe, the counter and the line keep their values.
- R9: A valid byte offered while ready is low is ignored. The frame in flight keeps the bits captured at its start.
- R10: A byte can be accepted in the cycle after the counter returns to 9, and its start bit comes on the next strobe. The stop slot always lasts at least one strobe period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A byte is offered on in_byte |
| in_byte | input | 8 | Byte to transmit |
| in_ready | output | 1 | The block can take a byte this cycle |
| adv | input | 1 | Bit-advance strobe, one slot per cycle it is high |
| line_o | output | 1 | Serial line |
| state_o | output | 4 | Frame slot counter, 9 = idle/stop |

## Verification
All results come from registers. A capture edge shows up as a low ready one cycle later. A strobe edge shows up in the counter and on the line one cycle later. The start bit therefore appears one cycle after the first strobe edge that follows the capture edge.

The bench updates its behavioural model on the same rising edge the design uses. It compares the counter, the line and ready at the following falling edge, every cycle. Inputs also change only on falling edges, so each comparison sees exactly the effect of one edge.

Directed checks for reset, idle strobes and the start bit sample at the falling edge right after the edge that should have caused the change.

// File: rtl/ser8n1_pkg.sv
package ser8n1_pkg;

  // Action the sequencer requests from the bit path on a clock edge
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_START = 2'd1,
    EV_SHIFT = 2'd2,
    EV_STOP  = 2'd3
  } frame_ev_e;

endpackage

// File: rtl/ser8n1_seq.sv
module ser8n1_seq
  import ser8n1_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic                              adv,
  output logic [$clog2(DATA_W+2)-1:0]       state_o,
  output logic                              ready_o,
  output logic                              accept_o,
  output frame_ev_e                         ev_o
);

  localparam int STATE_W = $clog2(DATA_W + 2);
  localparam logic [STATE_W-1:0] IDLE_ST   = STATE_W'(DATA_W + 1);
  localparam logic [STATE_W-1:0] LAST_DATA = STATE_W'(DATA_W);

  logic [STATE_W-1:0] state_q, state_d;
  logic               pend_q, pend_d;
  logic               state_en, pend_en;
  logic               is_idle;
  frame_ev_e          ev_d;

  assign is_idle  = (state_q == IDLE_ST);
  assign ready_o  = is_idle && !pend_q;
  assign accept_o = in_valid && ready_o;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    ev_d     = EV_NONE;
    state_en = 1'b0;
    pend_en  = 1'b0;
    if (is_idle) begin
      if (pend_q && adv) begin
        state_d  = '0;
        pend_d   = 1'b0;
        ev_d     = EV_START;
        state_en = 1'b1;
        pend_en  = 1'b1;
      end else if (accept_o) begin
        pend_d  = 1'b1;
        pend_en = 1'b1;
      end
    end else if (adv) begin
      state_d  = state_q + 1'b1;
      ev_d     = (state_q == LAST_DATA) ? EV_STOP : EV_SHIFT;
      state_en = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= IDLE_ST;
      pend_q  <= 1'b0;
    end else begin
      if (state_en) state_q <= state_d;
      if (pend_en)  pend_q  <= pend_d;
    end
  end

  assign state_o = state_q;
  assign ev_o    = ev_d;

  AST_READY_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (state_q == IDLE_ST)); // R2
  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q <= IDLE_ST); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != IDLE_ST && adv) |=> (state_q == $past(state_q) + 1'b1)); // R5
  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q)); // R8
  AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IDLE_ST && !pend_q) |=> (state_q == IDLE_ST)); // R3
  AST_START_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IDLE_ST && pend_q && adv) |=> (state_q == '0)); // R4

endmodule

// File: rtl/ser8n1_shift.sv
module ser8n1_shift
  import ser8n1_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  frame_ev_e         ev,
  output logic              line_bit
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic              bit_q, bit_d;
  logic              sh_en, bit_en;

  // Next-state logic
  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    sh_en  = 1'b0;
    bit_en = 1'b0;
    if (load) begin
      sh_d  = din;
      sh_en = 1'b1;
    end
    unique case (ev)
      EV_START: begin
        bit_d  = 1'b0;
        bit_en = 1'b1;
      end
      EV_SHIFT: begin
        bit_d  = sh_q[DATA_W-1];
        sh_d   = {sh_q[DATA_W-2:0], 1'b0};
        bit_en = 1'b1;
        sh_en  = 1'b1;
      end
      EV_STOP: begin
        bit_d  = 1'b1;
        bit_en = 1'b1;
      end
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= 1'b1;
    end else begin
      if (sh_en)  sh_q  <= sh_d;
      if (bit_en) bit_q <= bit_d;
    end
  end

  assign line_bit = bit_q;

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_START) |=> !bit_q); // R4
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_STOP) |=> bit_q); // R7
  AST_MSB_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_SHIFT) |=> (bit_q == $past(sh_q[DATA_W-1]))); // R6

endmodule

// File: rtl/ser8n1_tx.sv
module ser8n1_tx
  import ser8n1_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [DATA_W-1:0]            in_byte,
  output logic                         in_ready,
  input  logic                         adv,
  output logic                         line_o,
  output logic [$clog2(DATA_W+2)-1:0]  state_o
);

  localparam int STATE_W = $clog2(DATA_W + 2);
  localparam logic [STATE_W-1:0] IDLE_ST = STATE_W'(DATA_W + 1);

  logic [STATE_W-1:0] state_w;
  logic               accept_w;
  logic               line_bit_w;
  frame_ev_e          ev_w;

  ser8n1_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .adv      (adv),
    .state_o  (state_w),
    .ready_o  (in_ready),
    .accept_o (accept_w),
    .ev_o     (ev_w)
  );

  ser8n1_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_w),
    .din      (in_byte),
    .ev       (ev_w),
    .line_bit (line_bit_w)
  );

  assign state_o = state_w;
  assign line_o  = line_bit_w | (state_w == IDLE_ST);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == IDLE_ST) |-> line_bit_w); // R7
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(line_o)); // R8

endmodule

// File: tb/sim_ser8n1_tx.sv
module sim_ser8n1_tx;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       in_ready;
  logic       adv;
  logic       line_o;
  logic [3:0] state_o;

  int n_chk;
  int n_bad;
  int cyc;
  bit cmp_on;

  // behavioural reference
  int       m_state;
  bit       m_pend;
  bit [7:0] m_byte;

  ser8n1_tx u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .in_ready (in_ready),
    .adv      (adv),
    .line_o   (line_o),
    .state_o  (state_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Model: a frame is 10 slots, slot 0 start, slots 1..8 data MSB first, 9 idle/stop
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 9;
      m_pend  = 0;
      m_byte  = 0;
    end else if (m_state == 9) begin
      if (m_pend && adv) begin
        m_state = 0;
        m_pend  = 0;
      end else if (!m_pend && in_valid) begin
        m_pend = 1;
        m_byte = in_byte;
      end
    end else if (adv) begin
      m_state = m_state + 1;
    end
  end

  function automatic int exp_line();
    if (m_state == 9) return 1;
    if (m_state == 0) return 0;
    return int'(m_byte[8 - m_state]);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected below %0d cycles", cyc, WATCHDOG);
      finish_run();
    end
    if (cmp_on && rst_n) begin
      check("R5 state", int'(state_o), m_state);
      check((m_state == 9) ? "R7 line" : "R6 line", int'(line_o), exp_line());
      check("R2 ready", int'(in_ready), (m_state == 9 && !m_pend) ? 1 : 0);
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; cmp_on = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; adv = 1'b0;
    repeat (3) @(negedge clk);
    // R1: values while in reset
    check("R1 state", int'(state_o), 9);
    check("R1 line", int'(line_o), 1);
    check("R1 ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 state after release", int'(state_o), 9);
    cmp_on = 1;

    // R3: strobes in idle with nothing waiting
    adv = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 state", int'(state_o), 9);
    check("R3 line", int'(line_o), 1);

    // R4: capture with a strobe on the same edge; start waits for the next strobe
    in_valid = 1'b1; in_byte = 8'hA5;
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 no start on capture edge", int'(state_o), 9);
    check("R2 ready low while waiting", int'(in_ready), 0);
    @(negedge clk);
    check("R4 start state", int'(state_o), 0);
    check("R4 start bit", int'(line_o), 0);
    repeat (12) @(negedge clk);

    // R8/R9: slow strobe, offer a different byte mid-frame
    adv = 1'b0;
    in_valid = 1'b1; in_byte = 8'h3C;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      adv = (i % 3 == 0);
      if (i == 10) begin
        in_valid = 1'b1; in_byte = 8'hFF;  // R9: ignored, ready is low
      end
      if (i == 12) in_valid = 1'b0;
      @(negedge clk);
    end
    adv = 1'b0;
    @(negedge clk);

    // R10: valid held across frames, strobe every cycle
    in_valid = 1'b1; in_byte = 8'h81; adv = 1'b1;
    for (int i = 0; i < 45; i++) begin
      if (i == 5) in_byte = 8'h5A;
      if (i == 20) in_byte = 8'h0F;
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (12) @(negedge clk);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      in_valid = ($urandom % 3) != 0;
      in_byte  = 8'($urandom);
      adv      = ($urandom % 2) != 0;
      @(negedge clk);
    end
    in_valid = 1'b0; adv = 1'b1;
    repeat (12) @(negedge clk);
    check("R7 idle at end", int'(line_o), 1);
    finish_run();
  end

endmodule